// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block is a small data cache that sits between a 32-bit byte-addressed processor and main memory. Each entry holds one 32-bit word, a tag and a valid flag, and every address maps to exactly one entry. A read that finds its word comes back in the same cycle. A read that misses stalls the processor, fetches the word from memory, installs it, and then hands it over.

Stores never read memory. A store overwrites the tag and data of its entry, sets the valid flag, and places the word in a four-deep write queue. The queue drains to memory while the processor keeps working, and it stalls the processor only when it is full. Before a read miss goes to memory, every queued store is written out first, so a refill can never overtake an older store.

The processor holds a request steady until `cpuStall` is low. The cache takes at most one request per cycle. The number of entries is set by `IDX_W`, which defaults to 16 entries so that simulation stays small.

Top module: `wtCache`

## Requirements
- R1: After reset every entry is invalid. `cpuStall`, `memRdReq` and `memWrValid` are low, and the first read of any address misses.
- R2: The entry index is `cpuAddr[IDX_W+1:2]` and the tag is `cpuAddr[31:IDX_W+2]`. Two addresses with the same index but different tags displace each other, so each misses after the other has been installed.
- R3: A read whose entry is valid and whose tag matches drives `cpuHit` high, `cpuStall` low and the stored word on `cpuRdata`, all in the cycle of the request.
- R4: A read miss holds `cpuStall` high and raises `memRdReq` with `memRdAddr` = `{cpuAddr[31:2],2'b00}`. It keeps `memRdReq` high until `memRdValid` arrives. In the cycle after the response, `cpuStall` is low and `cpuRdata` carries the returned word.
- R5: A store, whether it hits or misses, writes its tag and data into the indexed entry and sets the valid flag, with no memory read. A later read of that address hits with the stored data, and the entry's previous address then misses.
- R6: Every accepted store appears on the memory write port exactly once, as `memWrAddr` = `{cpuAddr[31:2],2'b00}` with `memWrData`, in the order the stores were accepted.
- R7: The write queue holds 4 stores. Up to 4 stores are accepted without stalling while memory is not ready. A further store sees `cpuStall` high until a queued store is taken by memory.
- R8: On a read miss, `memRdReq` is not raised until every store accepted earlier has been transferred on the write port.
- R9: `memRdReq` and `memWrValid` are never high in the same cycle.
- R10: Address bits 1:0 are ignored. Addresses that differ only in those bits hit the same word.
- R11: While `memWrValid` is high and `memWrReady` is low, `memWrValid`, `memWrAddr` and `memWrData` stay unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | Processor request present |
| cpuWe | input | 1 | 1 = store, 0 = load |
| cpuAddr | input | 32 | Byte address |
| cpuWdata | input | 32 | Store data |
| cpuRdata | output | 32 | Load data, valid when cpuHit and not stalled |
| cpuHit | output | 1 | Request matches a valid entry |
| cpuStall | output | 1 | Request not accepted this cycle; hold it |
| memWrValid | output | 1 | Write queue offers a word to memory |
| memWrReady | input | 1 | Memory accepts the offered word |
| memWrAddr | output | 32 | Word-aligned store address |
| memWrData | output | 32 | Store data to memory |
| memRdReq | output | 1 | Refill read request, held until response |
| memRdAddr | output | 32 | Word-aligned refill address |
| memRdValid | input | 1 | Refill word present |
| memRdData | input | 32 | Refill word |

## Verification
A valid flag, tag or data word that is wrong in the array shows up the first time that entry is read. It appears as a false hit with wrong data, or as an extra refill request, in the same cycle as the load. A wrong write-queue pointer or count shows up on the memory write port as a lost, repeated or reordered store. It can also show up as a stall arriving too early or too late on the fifth store while memory is not ready. An ordering fault between the queue and the refill path shows up as a refill request issued while a store is still untransferred, which is visible in the cycle the request rises.

// File: rtl/wtCachePkg.sv
package wtCachePkg;

  typedef struct packed {
    logic fill;   // install refill word into indexed entry
    logic store;  // install processor store into indexed entry
    logic push;   // enqueue store into write queue
  } ctrlStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DRAIN = 2'd1,
    ST_READ  = 2'd2
  } ctrlState_t;

endpackage

// File: rtl/wtWriteBuf.sv
module wtWriteBuf #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              push,
  input  logic [ADDR_W-1:0] pushAddr,
  input  logic [DATA_W-1:0] pushData,
  input  logic              drainEn,
  output logic              memWrValid,
  input  logic              memWrReady,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              full,
  output logic              empty
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [ADDR_W-1:0] addrQ [DEPTH];
  logic [DATA_W-1:0] dataQ [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;
  logic              pop;

  assign full       = (count == FULL_CNT);
  assign empty      = (count == '0);
  assign memWrValid = drainEn && !empty;
  assign memWrAddr  = addrQ[rdPtr];
  assign memWrData  = dataQ[rdPtr];
  assign pop        = memWrValid && memWrReady;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : gSlot
      always_ff @(posedge clk) begin
        if (push && (wrPtr == PTR_W'(g))) begin
          addrQ[g] <= pushAddr;
          dataQ[g] <= pushData;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R7: the controller never enqueues into a full queue
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    push |-> !full);

  // R11: an offered word is held until memory takes it
  a_r11_hold_offer: assert property (@(posedge clk) disable iff (!rstN)
    (memWrValid && !memWrReady && drainEn) |=>
      (memWrValid && $stable(memWrAddr) && $stable(memWrData)));

endmodule

// File: rtl/wtCacheData.sv
module wtCacheData
  import wtCachePkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [DATA_W-1:0] memRdData,
  output logic              lookupHit,
  output logic [DATA_W-1:0] cpuRdata
);

  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_LO  = IDX_W + 2;
  localparam int TAG_W   = ADDR_W - TAG_LO;

  logic [ENTRIES-1:0] validQ;
  logic [TAG_W-1:0]   tagQ  [ENTRIES];
  logic [DATA_W-1:0]  wordQ [ENTRIES];

  logic [IDX_W-1:0]  reqIdx;
  logic [TAG_W-1:0]  reqTag;
  logic [DATA_W-1:0] installWord;
  logic              install;

  assign reqIdx      = cpuAddr[TAG_LO-1:2];
  assign reqTag      = cpuAddr[ADDR_W-1:TAG_LO];
  assign install     = strobe.fill || strobe.store;
  assign installWord = strobe.fill ? memRdData : cpuWdata;

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : gEntry
      logic sel;
      assign sel = install && (reqIdx == IDX_W'(g));

      always_ff @(posedge clk) begin
        if (!rstN)    validQ[g] <= 1'b0;
        else if (sel) validQ[g] <= 1'b1;
      end

      always_ff @(posedge clk) begin
        if (sel) begin
          tagQ[g]  <= reqTag;
          wordQ[g] <= installWord;
        end
      end
    end
  endgenerate

  assign lookupHit = validQ[reqIdx] && (tagQ[reqIdx] == reqTag);
  assign cpuRdata  = wordQ[reqIdx];

  // R5: an installed entry matches its own address on the next cycle
  a_r5_install_matches: assert property (@(posedge clk) disable iff (!rstN)
    install |=> (validQ[$past(reqIdx)] && (tagQ[$past(reqIdx)] == $past(reqTag))));

endmodule

// File: rtl/wtCacheCtrl.sv
module wtCacheCtrl
  import wtCachePkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpuReq,
  input  logic        cpuWe,
  input  logic        lookupHit,
  input  logic        wbFull,
  input  logic        wbEmpty,
  input  logic        memRdValid,
  output ctrlStrobe_t strobe,
  output logic        cpuStall,
  output logic        cpuHit,
  output logic        memRdReq,
  output logic        drainEn
);

  ctrlState_t stateQ, stateD;
  logic       isRead, isWrite;

  assign isRead  = cpuReq && !cpuWe;
  assign isWrite = cpuReq && cpuWe;
  assign cpuHit  = cpuReq && lookupHit;
  assign drainEn = (stateQ != ST_READ);

  always_comb begin
    stateD   = stateQ;
    strobe   = '0;
    cpuStall = 1'b0;
    memRdReq = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (isRead && !lookupHit) begin
          cpuStall = 1'b1;
          stateD   = wbEmpty ? ST_READ : ST_DRAIN;
        end else if (isWrite) begin
          cpuStall     = wbFull;
          strobe.store = !wbFull;
          strobe.push  = !wbFull;
        end
      end
      ST_DRAIN: begin
        cpuStall = 1'b1;
        if (wbEmpty) stateD = ST_READ;
      end
      ST_READ: begin
        cpuStall = 1'b1;
        memRdReq = 1'b1;
        if (memRdValid) begin
          strobe.fill = 1'b1;
          stateD      = ST_IDLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  // R8: refill goes out only after the write queue is empty
  a_r8_drain_first: assert property (@(posedge clk) disable iff (!rstN)
    memRdReq |-> wbEmpty);

  // R7: a store meeting a full queue is stalled
  a_r7_full_stalls: assert property (@(posedge clk) disable iff (!rstN)
    (isWrite && wbFull) |-> cpuStall);

  // R3: a matching load is never stalled
  a_r3_hit_no_stall: assert property (@(posedge clk) disable iff (!rstN)
    (isRead && lookupHit) |-> !cpuStall);

  // R4: after a refill the held load hits
  a_r4_fill_then_hit: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fill && cpuReq) |=> (lookupHit && !cpuStall));

endmodule

// File: rtl/wtCache.sv
module wtCache
  import wtCachePkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 4,
  parameter int WB_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              cpuHit,
  output logic              cpuStall,
  output logic              memWrValid,
  input  logic              memWrReady,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              memRdReq,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic              memRdValid,
  input  logic [DATA_W-1:0] memRdData
);

  ctrlStrobe_t       strobe;
  logic              lookupHit, wbFull, wbEmpty, drainEn;
  logic [ADDR_W-1:0] wordAddr;

  assign wordAddr  = {cpuAddr[ADDR_W-1:2], 2'b00};
  assign memRdAddr = wordAddr;

  wtCacheCtrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .cpuReq     (cpuReq),
    .cpuWe      (cpuWe),
    .lookupHit  (lookupHit),
    .wbFull     (wbFull),
    .wbEmpty    (wbEmpty),
    .memRdValid (memRdValid),
    .strobe     (strobe),
    .cpuStall   (cpuStall),
    .cpuHit     (cpuHit),
    .memRdReq   (memRdReq),
    .drainEn    (drainEn)
  );

  wtCacheData #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
  ) data_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cpuAddr   (cpuAddr),
    .cpuWdata  (cpuWdata),
    .memRdData (memRdData),
    .lookupHit (lookupHit),
    .cpuRdata  (cpuRdata)
  );

  wtWriteBuf #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .DEPTH  (WB_DEPTH)
  ) wbuf_i (
    .clk        (clk),
    .rstN       (rstN),
    .push       (strobe.push),
    .pushAddr   (wordAddr),
    .pushData   (cpuWdata),
    .drainEn    (drainEn),
    .memWrValid (memWrValid),
    .memWrReady (memWrReady),
    .memWrAddr  (memWrAddr),
    .memWrData  (memWrData),
    .full       (wbFull),
    .empty      (wbEmpty)
  );

  // R9: only one kind of memory transaction at a time
  a_r9_single_txn: assert property (@(posedge clk) disable iff (!rstN)
    !(memRdReq && memWrValid));

  // R4: a refill request stays up until answered, address steady
  a_r4_req_held: assert property (@(posedge clk) disable iff (!rstN)
    (memRdReq && !memRdValid) |=> (memRdReq && $stable(memRdAddr)));

endmodule

// File: tb/wtCache_tb_top.sv
module wtCache_tb_top;

  localparam int RD_LAT = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuReq = 1'b0, cpuWe = 1'b0;
  logic [31:0] cpuAddr = '0, cpuWdata = '0;
  logic [31:0] cpuRdata;
  logic        cpuHit, cpuStall;
  logic        memWrValid, memWrReady = 1'b1;
  logic [31:0] memWrAddr, memWrData;
  logic        memRdReq, memRdValid = 1'b0;
  logic [31:0] memRdAddr, memRdData = '0;

  int total = 0, bad = 0;
  int rdCount = 0, wrN = 0, storesAccepted = 0;
  logic [31:0] wrAddrLog [64];
  logic [31:0] wrDataLog [64];
  logic [31:0] lastRdAddr = '0;

  always #4 clk = ~clk;

  wtCache dut_i (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .cpuRdata(cpuRdata),
    .cpuHit(cpuHit), .cpuStall(cpuStall), .memWrValid(memWrValid),
    .memWrReady(memWrReady), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .memRdReq(memRdReq), .memRdAddr(memRdAddr), .memRdValid(memRdValid),
    .memRdData(memRdData)
  );

  function automatic logic [31:0] memWord(input logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h3C00_00C3;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // memory read responder and R8/R9 monitor
  initial begin
    int lat;
    lat = RD_LAT;
    forever begin
      @(negedge clk); #1;
      if (rstN && memRdReq && memWrValid)
        check("R9", "read and write together", 32'd1, 32'd0);
      if (memRdValid) begin
        memRdValid = 1'b0;
      end else if (rstN && memRdReq) begin
        if (lat == RD_LAT) begin
          check("R8", "stores out before refill", wrN, storesAccepted);
          lastRdAddr = memRdAddr;
        end
        if (lat == 0) begin
          memRdValid = 1'b1;
          memRdData  = memWord(memRdAddr);
          rdCount++;
          lat = RD_LAT;
        end else begin
          lat--;
        end
      end
    end
  end

  // memory write logger and R11 monitor
  initial begin
    logic prevPend;
    logic [31:0] prevA, prevD;
    prevPend = 1'b0; prevA = '0; prevD = '0;
    forever begin
      @(negedge clk); #1;
      if (rstN) begin
        if (prevPend) begin
          check("R11", "valid held", {31'd0, memWrValid}, 32'd1);
          check("R11", "addr held", memWrAddr, prevA);
          check("R11", "data held", memWrData, prevD);
        end
        if (memWrValid && memWrReady && wrN < 64) begin
          wrAddrLog[wrN] = memWrAddr;
          wrDataLog[wrN] = memWrData;
          wrN++;
        end
        prevPend = memWrValid && !memWrReady;
        prevA = memWrAddr; prevD = memWrData;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    finishRun();
  end

  task automatic cpuAccess(input logic we, input logic [31:0] addr,
                           input logic [31:0] wd, output logic [31:0] rd,
                           output logic firstHit, output logic firstStall);
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = we; cpuAddr = addr; cpuWdata = wd;
    #1;
    firstHit = cpuHit; firstStall = cpuStall;
    while (cpuStall) begin
      @(negedge clk); #1;
    end
    rd = cpuRdata;
    if (we) storesAccepted++;
    @(negedge clk);
    cpuReq = 1'b0; cpuWe = 1'b0;
  endtask

  task automatic testReset();
    logic [31:0] rd; logic h, s; int r0;
    check("R1", "stall after reset", {31'd0, cpuStall}, 32'd0);
    check("R1", "memRdReq after reset", {31'd0, memRdReq}, 32'd0);
    check("R1", "memWrValid after reset", {31'd0, memWrValid}, 32'd0);
    r0 = rdCount;
    cpuAccess(1'b0, 32'h0000_0100, '0, rd, h, s);
    check("R1", "first read hit", {31'd0, h}, 32'd0);
    check("R4", "miss stalls", {31'd0, s}, 32'd1);
    check("R4", "refill address", lastRdAddr, 32'h0000_0100);
    check("R4", "refill count", rdCount - r0, 32'd1);
    check("R4", "miss data", rd, memWord(32'h0000_0100));
  endtask

  task automatic testHit();
    logic [31:0] rd; logic h, s; int r0;
    r0 = rdCount;
    cpuAccess(1'b0, 32'h0000_0100, '0, rd, h, s);
    check("R3", "hit flag", {31'd0, h}, 32'd1);
    check("R3", "no stall", {31'd0, s}, 32'd0);
    check("R3", "hit data", rd, memWord(32'h0000_0100));
    cpuAccess(1'b0, 32'h0000_0103, '0, rd, h, s);
    check("R10", "offset hit", {31'd0, h}, 32'd1);
    check("R10", "offset data", rd, memWord(32'h0000_0100));
    check("R3", "no refill on hit", rdCount - r0, 32'd0);
  endtask

  task automatic testConflict();
    logic [31:0] rd; logic h, s;
    cpuAccess(1'b0, 32'h0000_0140, '0, rd, h, s);
    check("R2", "same index new tag misses", {31'd0, h}, 32'd0);
    check("R2", "conflict data", rd, memWord(32'h0000_0140));
    cpuAccess(1'b0, 32'h0000_0100, '0, rd, h, s);
    check("R2", "evicted address misses", {31'd0, h}, 32'd0);
    check("R2", "reload refill address", lastRdAddr, 32'h0000_0100);
    cpuAccess(1'b0, 32'h0000_0104, '0, rd, h, s);
    check("R2", "neighbour index cold", {31'd0, h}, 32'd0);
    cpuAccess(1'b0, 32'h0000_0100, '0, rd, h, s);
    check("R2", "neighbour did not evict", {31'd0, h}, 32'd1);
  endtask

  task automatic testStore();
    logic [31:0] rd; logic h, s; int r0, w0;
    r0 = rdCount; w0 = wrN;
    cpuAccess(1'b1, 32'h0000_0202, 32'hDEAD_0001, rd, h, s);
    check("R5", "store miss no stall", {31'd0, s}, 32'd0);
    repeat (2) @(negedge clk);
    #2;
    check("R6", "store reached memory", wrN - w0, 32'd1);
    check("R6", "store address", wrAddrLog[w0], 32'h0000_0200);
    check("R6", "store data", wrDataLog[w0], 32'hDEAD_0001);
    cpuAccess(1'b0, 32'h0000_0200, '0, rd, h, s);
    check("R5", "read after store hits", {31'd0, h}, 32'd1);
    check("R5", "read after store data", rd, 32'hDEAD_0001);
    check("R5", "store did not read memory", rdCount - r0, 32'd0);
    cpuAccess(1'b1, 32'h0000_0140, 32'hBEEF_0002, rd, h, s);
    cpuAccess(1'b0, 32'h0000_0140, '0, rd, h, s);
    check("R5", "overwrite hits", {31'd0, h}, 32'd1);
    check("R5", "overwrite data", rd, 32'hBEEF_0002);
    cpuAccess(1'b0, 32'h0000_0100, '0, rd, h, s);
    check("R5", "old address displaced", {31'd0, h}, 32'd0);
  endtask

  task automatic testFull();
    logic [31:0] rd; logic h, s; int w0;
    repeat (4) @(negedge clk);
    w0 = wrN;
    memWrReady = 1'b0;
    for (int i = 0; i < 4; i++) begin
      cpuAccess(1'b1, 32'h0000_0400 + 32'(i * 4), 32'hA000_0000 + 32'(i), rd, h, s);
      check("R7", "store into non-full queue", {31'd0, s}, 32'd0);
    end
    fork
      cpuAccess(1'b1, 32'h0000_0410, 32'hA000_0004, rd, h, s);
      begin
        repeat (4) @(negedge clk);
        #1;
        check("R7", "fifth store stalls", {31'd0, cpuStall}, 32'd1);
        check("R7", "nothing drained yet", wrN - w0, 32'd0);
        @(negedge clk);
        memWrReady = 1'b1;
      end
    join
    check("R7", "fifth store first stall", {31'd0, s}, 32'd1);
    repeat (8) @(negedge clk);
    #2;
    check("R6", "five stores drained", wrN - w0, 32'd5);
    for (int i = 0; i < 5; i++) begin
      check("R6", "drain order addr", wrAddrLog[w0 + i], 32'h0000_0400 + 32'(i * 4));
      check("R6", "drain order data", wrDataLog[w0 + i], 32'hA000_0000 + 32'(i));
    end
  endtask

  task automatic testDrainFirst();
    logic [31:0] rd; logic h, s; int r0;
    memWrReady = 1'b0;
    cpuAccess(1'b1, 32'h0000_0500, 32'hC0DE_0005, rd, h, s);
    r0 = rdCount;
    fork
      cpuAccess(1'b0, 32'h0000_0618, '0, rd, h, s);
      begin
        repeat (5) @(negedge clk);
        #1;
        check("R8", "no refill while store queued", {31'd0, memRdReq}, 32'd0);
        check("R8", "read still stalled", {31'd0, cpuStall}, 32'd1);
        @(negedge clk);
        memWrReady = 1'b1;
      end
    join
    check("R8", "refill count", rdCount - r0, 32'd1);
    check("R8", "read data after drain", rd, memWord(32'h0000_0618));
    check("R6", "queued store went out", wrAddrLog[wrN - 1], 32'h0000_0500);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    testReset();
    testHit();
    testConflict();
    testStore();
    testFull();
    testDrainFirst();
    repeat (4) @(negedge clk);
    finishRun();
  end

endmodule